// File: doc/BRIEF.md
# Warp Memory Request Coalescer

This block takes one load request for a whole warp: 32 lane addresses, each naming a 4-byte word, plus one active bit per lane. It sorts the active lanes into the fewest aligned 128-byte line transactions. It then presents those transactions one at a time on a valid/ready memory request port. Each transaction carries the line number, which is address bits [31:7], and a 32-bit mask of the lanes that line serves.

When every active lane has been covered, a one-cycle done pulse fires. At the same time the block shows how many transactions the warp needed. A load/store front end uses it to turn per-lane addresses into memory traffic. Stride-1 warps cost one transaction, and scattered warps cost up to 32.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, `req_ready` is 1, while `mem_valid`, `done` and `txn_count` are 0.
- R2: When 32 active lanes address line base + 4*i with a line-aligned base, exactly one transaction is issued. It has mask 0xFFFFFFFF, and the count is 1.
- R3: With a line-aligned base and a stride of s words, lane i at base + 4*s*i needs exactly min(s, 32) transactions, and `txn_count` at done equals that number.
- R4: When the 32 active lanes all fall in different lines, 32 transactions are issued, each with a single mask bit.
- R5: Transactions are ordered as follows. Each one uses the line of the lowest-numbered active lane that has not yet been served.
- R6: Each issued mask has bit i set exactly for those active, not-yet-served lanes whose line equals the issued line. Masks are therefore non-empty and disjoint, and together they cover the active lanes.
- R7: Inactive lanes never appear in a mask and never select a line. A request with no active lanes issues no transaction and raises `done` one cycle after acceptance, with a count of 0.
- R8: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid`, `mem_line` and `mem_mask` hold their values on the next cycle.
- R9: A request is accepted only while `req_ready` is 1, which is the idle state. `req_ready` is 0 while a warp is in progress, and a `req_valid` seen then has no effect on the transactions issued.
- R10: `done` is high for exactly one cycle, in the cycle after the last handshake. It is never high together with `mem_valid`. `txn_count` is 6 bits wide.
- R11: `lane_misaligned[i]` is set at acceptance when lane i is active and its address bits [1:0] are non-zero. Those bits do not affect line grouping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Warp request offered |
| req_ready | output | 1 | Block is idle and takes a request |
| req_addr | input | 1024 | Lane byte addresses, lane i at bits [32i+31:32i] |
| req_active | input | 32 | Per-lane active bits |
| mem_valid | output | 1 | Line transaction offered |
| mem_ready | input | 1 | Memory accepts the transaction |
| mem_line | output | 25 | Line number (address bits [31:7]) |
| mem_mask | output | 32 | Lanes served by this transaction |
| done | output | 1 | One-cycle pulse: all active lanes covered |
| txn_count | output | 6 | Transactions used by the warp; valid with done |
| lane_misaligned | output | 32 | Active lanes with non-zero address bits [1:0] |

## Verification
Two functions can collide in the same cycle. One is a new warp offered on `req_valid`, and the other is a line transaction still stalled on `mem_ready`. The bench provokes this by raising `req_valid` with unrelated addresses in the middle of a warp issued under a stall pattern on `mem_ready`. It then judges the outcome in two ways: `req_ready` must be low at that moment, and every transaction that follows must still match the original warp's expected lines, masks and count. Stalled transactions are also compared cycle by cycle to confirm that line and mask are held.

// File: rtl/wc_pkg.sv
package wc_pkg;
  typedef enum logic [0:0] {
    WC_IDLE  = 1'b0,
    WC_ISSUE = 1'b1
  } wc_state_e;
endpackage

// File: rtl/wc_leader_pick.sv
module wc_leader_pick #(
  parameter int LANES = 32,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [LANES-1:0] pending,
  output logic [IDX_W-1:0] leader_idx,
  output logic             leader_any
);
  function automatic logic [IDX_W-1:0] lowest_set(input logic [LANES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  assign leader_idx = lowest_set(pending);
  assign leader_any = |pending;
endmodule

// File: rtl/wc_line_match.sv
module wc_line_match #(
  parameter int LANES  = 32,
  parameter int LINE_W = 25
) (
  input  logic [LANES-1:0][LINE_W-1:0] lane_line,
  input  logic [LANES-1:0]             pending,
  input  logic [LINE_W-1:0]            ref_line,
  output logic [LANES-1:0]             hit
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign hit[g] = pending[g] && (lane_line[g] == ref_line);
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int LANES      = 32,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int WORD_BYTES = 4,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int ALIGN_W = $clog2(WORD_BYTES),
  localparam int LINE_W  = ADDR_W - OFF_W,
  localparam int IDX_W   = $clog2(LANES),
  localparam int CNT_W   = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]        req_active,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic [LINE_W-1:0]       mem_line,
  output logic [LANES-1:0]        mem_mask,
  output logic                    done,
  output logic [CNT_W-1:0]        txn_count,
  output logic [LANES-1:0]        lane_misaligned
);
  import wc_pkg::*;

  wc_state_e                   st_q;
  logic [LANES-1:0][LINE_W-1:0] line_q;
  logic [LANES-1:0]            pend_q;
  logic [CNT_W-1:0]            cnt_q;
  logic [LANES-1:0]            mis_q;

  // Named events for the checker
  logic accept;
  logic issue_fire;
  logic finish;

  logic [IDX_W-1:0]            leader_idx;
  logic                        leader_any;
  logic [LINE_W-1:0]           leader_line;
  logic [LANES-1:0]            hit;
  logic [LANES-1:0][LINE_W-1:0] in_line;
  logic [LANES-1:0]            in_mis;

  function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  function automatic logic word_misaligned(input logic [ADDR_W-1:0] a);
    return |a[ALIGN_W-1:0];
  endfunction

  function automatic logic [LINE_W-1:0] pick_line(
      input logic [LANES-1:0][LINE_W-1:0] lines, input logic [IDX_W-1:0] idx);
    logic [LINE_W-1:0] r;
    r = '0;
    for (int i = 0; i < LANES; i++) begin
      if (IDX_W'(i) == idx) r = lines[i];
    end
    return r;
  endfunction

  // Word-offset bits inside a line never influence grouping
  logic unused_word_bits;
  logic [LANES-1:0] word_bits_fold;

  for (genvar g = 0; g < LANES; g++) begin : g_split
    assign in_line[g]        = line_of(req_addr[g*ADDR_W +: ADDR_W]);
    assign in_mis[g]         = req_active[g] && word_misaligned(req_addr[g*ADDR_W +: ADDR_W]);
    assign word_bits_fold[g] = ^req_addr[g*ADDR_W + ALIGN_W +: (OFF_W - ALIGN_W)];
  end
  assign unused_word_bits = ^word_bits_fold;

  wc_leader_pick #(.LANES(LANES)) u_pick (
    .pending    (pend_q),
    .leader_idx (leader_idx),
    .leader_any (leader_any)
  );

  assign leader_line = pick_line(line_q, leader_idx);

  wc_line_match #(.LANES(LANES), .LINE_W(LINE_W)) u_match (
    .lane_line (line_q),
    .pending   (pend_q),
    .ref_line  (leader_line),
    .hit       (hit)
  );

  assign req_ready  = (st_q == WC_IDLE);
  assign accept     = req_ready && req_valid;
  assign mem_valid  = (st_q == WC_ISSUE) && leader_any;
  assign issue_fire = mem_valid && mem_ready;
  assign finish     = (st_q == WC_ISSUE) && !leader_any;
  assign mem_line   = leader_line;
  assign mem_mask   = hit;
  assign done       = finish;
  assign txn_count  = cnt_q;
  assign lane_misaligned = mis_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= WC_IDLE;
      line_q <= '0;
      pend_q <= '0;
      cnt_q  <= '0;
      mis_q  <= '0;
    end else begin
      unique case (st_q)
        WC_IDLE: begin
          if (accept) begin
            st_q   <= WC_ISSUE;
            line_q <= in_line;
            pend_q <= req_active;
            cnt_q  <= '0;
            mis_q  <= in_mis;
          end
        end
        WC_ISSUE: begin
          if (issue_fire) begin
            pend_q <= pend_q & ~hit;
            cnt_q  <= cnt_q + CNT_W'(1);
          end
          if (finish) st_q <= WC_IDLE;
        end
        default: st_q <= WC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wc_checker.sv
module wc_checker #(
  parameter int LANES  = 32,
  parameter int LINE_W = 25,
  parameter int CNT_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic [LANES-1:0]  req_active,
  input logic              accept,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [LINE_W-1:0] mem_line,
  input logic [LANES-1:0]  mem_mask,
  input logic              done,
  input logic [CNT_W-1:0]  txn_count
);
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_line) && $stable(mem_mask));

  p_mask_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_mask != '0));

  p_mask_disjoint_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready |=> !mem_valid || ((mem_mask & $past(mem_mask)) == '0));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_valid && !done);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_valid);

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (txn_count <= CNT_W'(LANES)));

  p_empty_warp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (req_active == '0) |=> done && (txn_count == '0));
endmodule

bind warp_coalescer wc_checker #(.LANES(LANES), .LINE_W(LINE_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .req_active (req_active),
  .accept     (accept),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_line   (mem_line),
  .mem_mask   (mem_mask),
  .done       (done),
  .txn_count  (txn_count)
);

// File: tb/tb_warp_coalescer.sv
`timescale 1ns/1ps
module tb_warp_coalescer;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [N*32-1:0] req_addr = '0;
  logic [N-1:0]  req_active = '0;
  logic          mem_valid;
  logic          mem_ready = 1'b0;
  logic [24:0]   mem_line;
  logic [N-1:0]  mem_mask;
  logic          done;
  logic [5:0]    txn_count;
  logic [N-1:0]  lane_misaligned;

  always #2.5 clk = ~clk;

  warp_coalescer dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_active(req_active), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_line(mem_line), .mem_mask(mem_mask),
    .done(done), .txn_count(txn_count), .lane_misaligned(lane_misaligned)
  );

  int checks = 0;
  int errors = 0;

  logic [31:0] a [N];
  logic [N-1:0] act;
  logic [24:0] exp_line [N];
  logic [N-1:0] exp_mask [N];
  int exp_n;
  logic [N-1:0] exp_mis;

  task automatic check(input bit ok, input string req, input logic [63:0] actual, input logic [63:0] expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  // Expected transactions from the grouping rule
  task automatic model();
    logic [N-1:0] done_l;
    done_l = '0;
    exp_n = 0;
    exp_mis = '0;
    for (int i = 0; i < N; i++) begin
      if (act[i] && a[i][1:0] != 2'b00) exp_mis[i] = 1'b1;
    end
    for (int i = 0; i < N; i++) begin
      if (act[i] && !done_l[i]) begin
        logic [N-1:0] m;
        m = '0;
        for (int j = i; j < N; j++) begin
          if (act[j] && !done_l[j] && (a[j] >> 7) == (a[i] >> 7)) m[j] = 1'b1;
        end
        exp_line[exp_n] = a[i][31:7];
        exp_mask[exp_n] = m;
        exp_n++;
        done_l = done_l | m;
      end
    end
  endtask

  task automatic run_warp(input string tag, input int bp, input bit poke);
    int k;
    int cyc;
    bit held;
    logic [24:0] pl;
    logic [N-1:0] pm;
    bit finished;
    model();
    @(negedge clk);
    check(req_ready == 1'b1, {tag, " R9 idle ready"}, 64'(req_ready), 64'd1);
    for (int i = 0; i < N; i++) req_addr[i*32 +: 32] = a[i];
    req_active = act;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    k = 0; cyc = 0; held = 0; finished = 0; pl = '0; pm = '0;
    while (!finished && cyc < 2000) begin
      mem_ready = (bp == 0) ? 1'b1 : ((cyc % bp) != 0);
      if (poke && cyc == 1) begin
        req_valid = 1'b1;
        req_active = '1;
        req_addr = {N{32'hDEAD_0000}};
      end else begin
        req_valid = 1'b0;
      end
      #1;
      if (poke && cyc == 1)
        check(req_ready == 1'b0, {tag, " R9 busy not ready"}, 64'(req_ready), 64'd0);
      if (held) begin
        check(mem_valid == 1'b1, {tag, " R8 valid held"}, 64'(mem_valid), 64'd1);
        check(mem_line == pl && mem_mask == pm, {tag, " R8 payload held"},
              {7'd0, mem_line, mem_mask}, {7'd0, pl, pm});
      end
      if (mem_valid) begin
        check(done == 1'b0, {tag, " R10 done with valid"}, 64'(done), 64'd0);
        if (k < exp_n) begin
          check(mem_line == exp_line[k], {tag, " R5 line order"}, 64'(mem_line), 64'(exp_line[k]));
          check(mem_mask == exp_mask[k], {tag, " R6 lane mask"}, 64'(mem_mask), 64'(exp_mask[k]));
        end else begin
          check(1'b0, {tag, " R6 extra transaction"}, 64'(k), 64'(exp_n));
        end
        if (mem_ready) begin k++; held = 0; end
        else begin held = 1; pl = mem_line; pm = mem_mask; end
      end else begin
        held = 0;
      end
      if (done) begin
        finished = 1;
        check(txn_count == 6'(exp_n), {tag, " R3 txn_count"}, 64'(txn_count), 64'(exp_n));
        check(k == exp_n, {tag, " R6 transactions seen"}, 64'(k), 64'(exp_n));
        check(lane_misaligned == exp_mis, {tag, " R11 misaligned lanes"},
              64'(lane_misaligned), 64'(exp_mis));
      end
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    mem_ready = 1'b0;
    check(finished == 1'b1, {tag, " R10 done reached"}, 64'(finished), 64'd1);
    #1;
    check(done == 1'b0 && req_ready == 1'b1, {tag, " R10 single pulse"},
          {62'd0, done, req_ready}, 64'd1);
  endtask

  task automatic set_stride(input logic [31:0] base, input int s);
    for (int i = 0; i < N; i++) a[i] = base + 32'(4 * s * i);
    act = '1;
  endtask

  task automatic t_reset();
    #1;
    check(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
    check(mem_valid == 1'b0, "R1 mem_valid", 64'(mem_valid), 64'd0);
    check(done == 1'b0, "R1 done", 64'(done), 64'd0);
    check(txn_count == 6'd0, "R1 txn_count", 64'(txn_count), 64'd0);
  endtask

  task automatic t_contiguous();
    set_stride(32'h0000_1000, 1);
    run_warp("R2 contiguous", 0, 0);
    check(exp_n == 1 && exp_mask[0] == '1, "R2 single full transaction", 64'(exp_n), 64'd1);
  endtask

  task automatic t_strides();
    int sv [5] = '{2, 5, 17, 32, 40};
    foreach (sv[x]) begin
      set_stride(32'h0004_0000, sv[x]);
      run_warp("R3 stride", 0, 0);
      check(exp_n == ((sv[x] < 32) ? sv[x] : 32), "R3 min(s,32)", 64'(exp_n), 64'(sv[x]));
    end
  endtask

  task automatic t_scatter();
    for (int i = 0; i < N; i++) a[i] = 32'h8000_0000 + 32'(i * 4096) + 32'(i * 4);
    act = '1;
    run_warp("R4 scatter", 3, 0);
    check(exp_n == 32, "R4 thirty-two transactions", 64'(exp_n), 64'd32);
  endtask

  task automatic t_order();
    for (int i = 0; i < N; i++) a[i] = 32'h0002_0000 + 32'(128 * (3 - (i % 4))) + 32'(4 * i);
    act = 32'h7FFF_FFFE;
    run_warp("R5 order R7 inactive", 2, 0);
    check(exp_mask[0] == 32'h2222_2222, "R5 first leader lane1", 64'(exp_mask[0]), 64'h2222_2222);
  endtask

  task automatic t_empty();
    set_stride(32'h0000_0000, 1);
    act = '0;
    run_warp("R7 empty", 0, 0);
  endtask

  task automatic t_busy_poke();
    set_stride(32'h0010_0000, 8);
    act = 32'hF0F0_FFFF;
    run_warp("R9 busy poke R8", 2, 1);
  endtask

  task automatic t_misalign();
    for (int i = 0; i < N; i++) a[i] = 32'h0003_0000 + 32'(4 * i) + 32'(i % 4);
    act = 32'hFFFF_FFFD;
    run_warp("R11 misaligned", 0, 0);
    check(exp_n == 1, "R11 alignment bits ignored", 64'(exp_n), 64'd1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_contiguous();
    t_strides();
    t_scatter();
    t_order();
    t_empty();
    t_busy_poke();
    t_misalign();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule